// File: doc/BRIEF.md
# Single-Byte Serial Port with APB Register Access

This block is a serial port for an APB bus. It drives one transmit line and samples one receive line. There are no handshake wires. Each direction stores exactly one byte. Software writes a byte to the data word and the serializer sends it. When a byte has been received it waits in the receive holding byte until software reads the data word.

Bit timing comes from a single integer divider. The divider gives the number of system clock cycles in one bit, and values below a parameterised floor are raised to that floor. The receiver synchronises the line and detects a falling edge. It then samples the start bit and every later bit at the middle of its bit time.

Four interrupt sources each have their own enable and their own output wire:
- transmit holding byte emptied,
- receive holding byte filled,
- transmit overrun,
- receive overrun.

A pending interrupt is cleared by writing ones to the interrupt word. The transmit interrupt fires on an event only: it is raised when the holding byte passes from full to empty. It is never raised simply because the buffer is empty.

Top module: `apb_byte_uart`

## Requirements
- R1: After reset every readable word returns 0, the transmit line is high and all four interrupt outputs are low.
- R2: Word map (byte address, bits [4:2] decoded): 0x00 data, 0x04 status, 0x08 control, 0x0C interrupt (read = pending, write = clear), 0x10 divider. The control and divider words read back what was written. Control bits are: 0 transmit enable, 1 receive enable, 2 transmit-interrupt enable, 3 receive-interrupt enable, 4 transmit-overrun interrupt enable, 5 receive-overrun interrupt enable, 6 fast transmit test. Status bits are: 0 transmit holding full, 1 receive holding full, 2 transmit overrun, 3 receive overrun. Interrupt bits are: 0 transmit, 1 receive, 2 transmit overrun, 3 receive overrun.
- R3: A frame is one low start bit, then eight data bits LSB first, then one high stop bit. Each bit lasts the effective divider in cycles, and the line idles high. When transmit is enabled and the serializer is idle, the serializer takes the holding byte on the clock edge after the write. The start bit appears from that edge onward.
- R4: The effective divider is the larger of the divider word and MIN_DIV. This applies to both transmit and receive.
- R5: With control bit 6 set, every transmitted bit lasts exactly one clock cycle.
- R6: A write to the data word while the transmit holding byte is full discards the byte and sets status bit 2. If control bit 4 is set, it also raises interrupt bit 2. A byte written while the serializer is busy waits in the holding byte and sets status bit 0.
- R7: Interrupt bit 0 is set only when the transmit holding byte passes to the serializer while control bit 2 is set. Setting control bit 2 while the buffer is empty does not raise it.
- R8: A received frame sampled at mid-bit is stored in the receive holding byte and sets status bit 1. If control bit 3 is set, it also raises interrupt bit 1. Reading the data word returns the byte and clears status bit 1.
- R9: A frame that completes while status bit 1 is set is discarded and sets status bit 3. If control bit 5 is set, it also raises interrupt bit 3. The earlier byte stays readable.
- R10: Writing a 1 to an interrupt-word bit clears that pending bit. Writing a 1 to status bit 2 or 3 clears that overrun flag. Zero bits in such a write leave the flags unchanged.
- R11: With control bit 0 clear, a written byte stays in the holding byte and the line stays high. With control bit 1 clear, incoming frames are ignored. With an interrupt enable clear, its event leaves the pending bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| serIn | input | 1 | Serial receive line |
| serOut | output | 1 | Serial transmit line |
| irqTx | output | 1 | Transmit holding byte emptied |
| irqRx | output | 1 | Receive holding byte filled |
| irqTxOvr | output | 1 | Transmit overrun |
| irqRxOvr | output | 1 | Receive overrun |

## Verification
The bench builds the block with DIV_W = 8 and MIN_DIV = 4, so frames are short and many fit in a short run. With these values a divider of 2 falls below the floor, which lets the bench check the clamp in both directions. A divider of 6 sits above the floor, and the fast test mode shrinks each bit to a single cycle. A behavioural model predicts the serial line and the four interrupt wires on every clock, and directed reads check the status and data words after each scenario.

// File: rtl/ubu_pkg.sv
package ubu_pkg;
  // word indices (address bits [4:2])
  localparam int IDX_DATA = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_INT  = 3;
  localparam int IDX_DIV  = 4;

  localparam int CTRL_W = 7;
  localparam int IRQ_W  = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic       txValid;
    logic [7:0] txByte;
    logic       txEn;
    logic       rxEn;
    logic       hsTest;
  } dpCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic       txTake;
    logic       rxDone;
    logic [7:0] rxByte;
  } dpEvt_t;
endpackage

// File: rtl/ubu_regs.sv
module ubu_regs
  import ubu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIV_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  dpEvt_t            evt,
  output dpCmd_t            cmd,
  output logic [DIV_W-1:0]  divider,
  output logic [IRQ_W-1:0]  pend
);
  localparam int WI = ADDR_W - 2;

  logic [WI-1:0]     wordIdx;
  logic              acc, wr, rd;
  logic              isData, isStat, isCtrl, isInt, isDiv;
  logic [CTRL_W-1:0] ctrlR;
  logic [DIV_W-1:0]  divR;
  logic [7:0]        txBuf, rxBuf;
  logic              txFull, txOvr, rxFull, rxOvr;
  logic [IRQ_W-1:0]  pendR, setP, clrP;
  logic              wrData, rdData, txOvrEv, rxAccept, rxOvrEv;
  logic              unusedBits;

  assign wordIdx = paddr[ADDR_W-1:2];
  assign acc     = psel & penable;
  assign wr      = acc & pwrite;
  assign rd      = acc & ~pwrite;
  assign isData  = (wordIdx == WI'(IDX_DATA));
  assign isStat  = (wordIdx == WI'(IDX_STAT));
  assign isCtrl  = (wordIdx == WI'(IDX_CTRL));
  assign isInt   = (wordIdx == WI'(IDX_INT));
  assign isDiv   = (wordIdx == WI'(IDX_DIV));
  assign unusedBits = ^{pwdata, paddr[1:0]};

  assign wrData   = wr & isData;
  assign rdData   = rd & isData;
  assign txOvrEv  = wrData & txFull;
  assign rxAccept = evt.rxDone & (~rxFull | rdData);
  assign rxOvrEv  = evt.rxDone & rxFull & ~rdData;

  assign setP = {rxOvrEv & ctrlR[5], txOvrEv & ctrlR[4],
                 rxAccept & ctrlR[3], evt.txTake & ctrlR[2]};
  assign clrP = (wr & isInt) ? pwdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlR  <= '0;
      divR   <= '0;
      txBuf  <= '0;
      rxBuf  <= '0;
      txFull <= 1'b0;
      txOvr  <= 1'b0;
      rxFull <= 1'b0;
      rxOvr  <= 1'b0;
      pendR  <= '0;
    end else begin
      if (wr && isCtrl) ctrlR <= pwdata[CTRL_W-1:0];
      if (wr && isDiv)  divR  <= pwdata[DIV_W-1:0];
      // transmit holding byte
      if (wrData && !txFull) begin
        txFull <= 1'b1;
        txBuf  <= pwdata[7:0];
      end else if (evt.txTake) begin
        txFull <= 1'b0;
      end
      // receive holding byte
      if (rxAccept) begin
        rxFull <= 1'b1;
        rxBuf  <= evt.rxByte;
      end else if (rdData) begin
        rxFull <= 1'b0;
      end
      txOvr <= txOvrEv | (txOvr & ~(wr & isStat & pwdata[2]));
      rxOvr <= rxOvrEv | (rxOvr & ~(wr & isStat & pwdata[3]));
      pendR <= (pendR & ~clrP) | setP;
    end
  end

  always_comb begin
    prdata = '0;
    if (isData)      prdata = 32'(rxBuf);
    else if (isStat) prdata = {28'd0, rxOvr, txOvr, rxFull, txFull};
    else if (isCtrl) prdata = 32'(ctrlR);
    else if (isInt)  prdata = 32'(pendR);
    else if (isDiv)  prdata = 32'(divR);
  end

  assign cmd.txValid = txFull;
  assign cmd.txByte  = txBuf;
  assign cmd.txEn    = ctrlR[0];
  assign cmd.rxEn    = ctrlR[1];
  assign cmd.hsTest  = ctrlR[6];
  assign divider     = divR;
  assign pend        = pendR;

  AST_TAKE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    evt.txTake |-> txFull); // R6
  AST_TXIRQ_ON_EMPTYING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendR[0]) |-> ($past(txFull) && !txFull)); // R7
  AST_RXIRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendR[1]) |-> rxFull); // R8
  AST_TXOVR_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendR[2]) |-> txOvr); // R6
endmodule

// File: rtl/ubu_datapath.sv
module ubu_datapath
  import ubu_pkg::*;
#(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [DIV_W-1:0] divider,
  input  logic             serIn,
  output logic             serOut,
  output dpEvt_t           evt
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);
  localparam logic [3:0] LAST_TX_BIT = 4'd9;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_e;

  logic [DIV_W-1:0] effDiv, txBitLen;
  // transmit
  logic             txBusy, txTake, serOutR;
  logic [DIV_W-1:0] txCnt;
  logic [3:0]       txBit;
  logic [8:0]       txShift;
  // receive
  logic             rxMeta, rxSync;
  rxState_e         rxState;
  logic [DIV_W-1:0] rxCnt;
  logic [2:0]       rxBitN;
  logic [7:0]       rxSh, rxByteR;
  logic             rxDoneR;

  assign effDiv   = (divider < FLOOR) ? FLOOR : divider;
  assign txBitLen = cmd.hsTest ? DIV_W'(1) : effDiv;
  assign txTake   = ~txBusy & cmd.txValid & cmd.txEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      serOutR <= 1'b1;
      txCnt   <= '0;
      txBit   <= '0;
      txShift <= '1;
    end else if (txTake) begin
      txBusy  <= 1'b1;
      txShift <= {1'b1, cmd.txByte};
      serOutR <= 1'b0;
      txCnt   <= txBitLen - 1'b1;
      txBit   <= '0;
    end else if (txBusy) begin
      if (txCnt != '0) begin
        txCnt <= txCnt - 1'b1;
      end else if (txBit == LAST_TX_BIT) begin
        txBusy  <= 1'b0;
        serOutR <= 1'b1;
      end else begin
        serOutR <= txShift[0];
        txShift <= {1'b1, txShift[8:1]};
        txBit   <= txBit + 1'b1;
        txCnt   <= txBitLen - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxBitN  <= '0;
      rxSh    <= '0;
      rxByteR <= '0;
      rxDoneR <= 1'b0;
    end else begin
      rxMeta  <= serIn;
      rxSync  <= rxMeta;
      rxDoneR <= 1'b0;
      if (rxState == RX_IDLE) begin
        if (cmd.rxEn && !rxSync) begin
          rxState <= RX_START;
          rxCnt   <= (effDiv >> 1) - 1'b1;
        end
      end else if (rxCnt != '0) begin
        rxCnt <= rxCnt - 1'b1;
      end else begin
        case (rxState)
          RX_START: begin
            if (!rxSync) begin
              rxState <= RX_DATA;
              rxCnt   <= effDiv - 1'b1;
              rxBitN  <= '0;
            end else begin
              rxState <= RX_IDLE;
            end
          end
          RX_DATA: begin
            rxSh  <= {rxSync, rxSh[7:1]};
            rxCnt <= effDiv - 1'b1;
            if (rxBitN == 3'd7) rxState <= RX_STOP;
            else                rxBitN  <= rxBitN + 1'b1;
          end
          default: begin
            rxDoneR <= 1'b1;
            rxByteR <= rxSh;
            rxState <= RX_IDLE;
          end
        endcase
      end
    end
  end

  assign serOut     = serOutR;
  assign evt.txTake = txTake;
  assign evt.rxDone = rxDoneR;
  assign evt.rxByte = rxByteR;

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !serOutR); // R3
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> serOutR); // R3
  AST_RX_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneR |=> !rxDoneR); // R8
endmodule

// File: rtl/apb_byte_uart.sv
module apb_byte_uart
  import ubu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              serIn,
  output logic              serOut,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqTxOvr,
  output logic              irqRxOvr
);
  dpCmd_t           cmd;
  dpEvt_t           evt;
  logic [DIV_W-1:0] divider;
  logic [IRQ_W-1:0] pend;

  ubu_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uRegs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .evt(evt), .cmd(cmd),
    .divider(divider), .pend(pend)
  );

  ubu_datapath #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divider(divider), .serIn(serIn),
    .serOut(serOut), .evt(evt)
  );

  assign irqTx    = pend[0];
  assign irqRx    = pend[1];
  assign irqTxOvr = pend[2];
  assign irqRxOvr = pend[3];
endmodule

// File: tb/tb_apb_byte_uart.sv
module tb_apb_byte_uart;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DIV_W = 8;
  localparam int MIN_DIV = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic serIn = 1'b1, serOut, irqTx, irqRx, irqTxOvr, irqRxOvr;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 1'b0;

  apb_byte_uart #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .serIn(serIn),
    .serOut(serOut), .irqTx(irqTx), .irqRx(irqRx), .irqTxOvr(irqTxOvr),
    .irqRxOvr(irqRxOvr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mCtrl, mDiv, mPend;
  bit mTxFull, mTxOvr, mRxFull, mRxOvr, mBusy;
  int mTxBuf, mRxBuf, mStart, mLen;
  logic [9:0] mFrame;
  int rxDueQ[$];
  int rxValQ[$];

  function automatic int effOf(int d);
    return (d < MIN_DIV) ? MIN_DIV : d;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mCtrl = 0; mDiv = 0; mPend = 0; mTxFull = 0; mTxOvr = 0;
      mRxFull = 0; mRxOvr = 0; mBusy = 0; mTxBuf = 0; mRxBuf = 0;
      rxDueQ.delete(); rxValQ.delete();
    end else begin
      bit acc, wrD, rdD, take, txOv, rxEv, rxAcc, rxOv;
      int idx, setP, rxv;
      acc  = psel && penable;
      idx  = int'(paddr) >> 2;
      wrD  = acc && pwrite && idx == 0;
      rdD  = acc && !pwrite && idx == 0;
      take = !mBusy && mTxFull && mCtrl[0];
      txOv = wrD && mTxFull;
      rxEv = 0; rxv = 0;
      if (rxDueQ.size() > 0 && rxDueQ[0] == cyc) begin
        rxEv = 1; rxv = rxValQ[0];
        void'(rxDueQ.pop_front()); void'(rxValQ.pop_front());
      end
      rxAcc = rxEv && (!mRxFull || rdD);
      rxOv  = rxEv && mRxFull && !rdD;
      setP = 0;
      if (take && mCtrl[2]) setP |= 1;
      if (rxAcc && mCtrl[3]) setP |= 2;
      if (txOv && mCtrl[4]) setP |= 4;
      if (rxOv && mCtrl[5]) setP |= 8;
      if (mBusy && (cyc - mStart) >= 10 * mLen) mBusy = 0;
      if (take) begin
        mBusy = 1; mStart = cyc;
        mLen = mCtrl[6] ? 1 : effOf(mDiv);
        mFrame = {1'b1, 8'(mTxBuf), 1'b0};
        mTxFull = 0;
      end
      if (wrD && !txOv) begin mTxFull = 1; mTxBuf = int'(pwdata[7:0]); end
      if (rxAcc) begin mRxFull = 1; mRxBuf = rxv; end
      else if (rdD) mRxFull = 0;
      if (acc && pwrite && idx == 1) begin
        if (pwdata[2]) mTxOvr = 0;
        if (pwdata[3]) mRxOvr = 0;
      end
      if (txOv) mTxOvr = 1;
      if (rxOv) mRxOvr = 1;
      if (acc && pwrite && idx == 3) mPend &= ~int'(pwdata[3:0]);
      mPend |= setP;
      if (acc && pwrite && idx == 2) mCtrl = int'(pwdata[6:0]);
      if (acc && pwrite && idx == 4) mDiv = int'(pwdata[DIV_W-1:0]);
    end
  end

  function automatic logic expSer();
    if (!mBusy) return 1'b1;
    return mFrame[(cyc - mStart) / mLen];
  endfunction

  // per-clock comparison of the serial line and interrupt wires
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [3:0] gotIrq, expIrq;
      gotIrq = {irqRxOvr, irqTxOvr, irqRx, irqTx};
      expIrq = 4'(mPend);
      compared++;
      if (serOut !== expSer()) begin
        mismatched++;
        $display("FAIL R3/R4/R5 serial line cycle %0d: got %b exp %b", cyc, serOut, expSer());
      end
      if (gotIrq !== expIrq) begin
        mismatched++;
        $display("FAIL R7/R8/R9/R11 irq wires cycle %0d: got %h exp %h", cyc, gotIrq, expIrq);
      end
    end
  end

  // ---------------- bus and line tasks ----------------
  task automatic apbWrite(input int a, input int d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = ADDR_W'(a); pwdata = 32'(d);
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input int a, input int exp, input string req);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = ADDR_W'(a);
    @(negedge clk);
    penable = 1;
    #1;
    compared++;
    if (prdata !== 32'(exp)) begin
      mismatched++;
      $display("FAIL %s read 0x%0h: got %h exp %h", req, a, prdata, 32'(exp));
    end
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendSer(input logic [7:0] b);
    int eff;
    logic [9:0] fr;
    eff = effOf(mDiv);
    fr = {1'b1, b, 1'b0};
    @(negedge clk);
    if (mCtrl[1]) begin
      rxDueQ.push_back(cyc + 4 + eff / 2 + 9 * eff);
      rxValQ.push_back(int'(b));
    end
    for (int k = 0; k < 10; k++) begin
      serIn = fr[k];
      repeat (eff) @(negedge clk);
    end
    serIn = 1'b1;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    waitCyc(4);
    rstN = 1'b1;
    // R1 reset state
    apbRead(32'h00, 0, "R1"); apbRead(32'h04, 0, "R1"); apbRead(32'h08, 0, "R1");
    apbRead(32'h0C, 0, "R1"); apbRead(32'h10, 0, "R1");
    // R2 map readback
    apbWrite(32'h10, 6);
    apbRead(32'h10, 6, "R2");
    apbWrite(32'h08, 32'h07);
    apbRead(32'h08, 32'h07, "R2");
    // R7 enabling with empty buffer raises nothing
    waitCyc(5);
    apbRead(32'h0C, 0, "R7");
    // R3 / R6 transmit, buffered second byte, overrun third
    apbWrite(32'h00, 32'hA5);
    apbWrite(32'h00, 32'h5A);
    apbRead(32'h04, 32'h1, "R6");
    apbWrite(32'h00, 32'hFF);
    apbRead(32'h04, 32'h5, "R6");
    apbRead(32'h0C, 32'h1, "R7");
    waitCyc(140);
    apbRead(32'h04, 32'h4, "R6");
    apbWrite(32'h0C, 32'h1);
    apbRead(32'h0C, 0, "R10");
    waitCyc(20);
    apbRead(32'h0C, 0, "R7");
    apbWrite(32'h04, 0);
    apbRead(32'h04, 32'h4, "R10");
    apbWrite(32'h04, 32'h4);
    apbRead(32'h04, 0, "R10");
    // R8 receive
    apbWrite(32'h08, 32'h3F);
    sendSer(8'h3C);
    waitCyc(8);
    apbRead(32'h04, 32'h2, "R8");
    apbRead(32'h0C, 32'h2, "R8");
    apbRead(32'h00, 32'h3C, "R8");
    apbRead(32'h04, 0, "R8");
    apbWrite(32'h0C, 32'hF);
    // R9 receive overrun
    sendSer(8'h11);
    sendSer(8'h22);
    waitCyc(8);
    apbRead(32'h04, 32'hA, "R9");
    apbRead(32'h0C, 32'hA, "R9");
    apbRead(32'h00, 32'h11, "R9");
    apbWrite(32'h0C, 32'hF);
    apbWrite(32'h04, 32'h8);
    apbRead(32'h04, 0, "R10");
    // R6 transmit overrun with interrupt
    apbWrite(32'h00, 32'h01);
    apbWrite(32'h00, 32'h02);
    apbWrite(32'h00, 32'h03);
    apbRead(32'h0C, 32'h5, "R6");
    waitCyc(140);
    apbWrite(32'h0C, 32'hF);
    apbWrite(32'h04, 32'hC);
    // R4 divider floor
    apbWrite(32'h10, 2);
    apbWrite(32'h00, 32'h96);
    waitCyc(50);
    sendSer(8'hC3);
    waitCyc(8);
    apbRead(32'h00, 32'hC3, "R4");
    apbWrite(32'h0C, 32'hF);
    // R5 fast test mode
    apbWrite(32'h10, 10);
    apbWrite(32'h08, 32'h7F);
    apbWrite(32'h00, 32'h69);
    waitCyc(20);
    apbRead(32'h04, 0, "R5");
    apbWrite(32'h08, 32'h3F);
    apbWrite(32'h0C, 32'hF);
    // R11 transmit disabled holds byte
    apbWrite(32'h10, 5);
    apbWrite(32'h08, 32'h3E);
    apbWrite(32'h00, 32'h81);
    waitCyc(60);
    apbRead(32'h04, 32'h1, "R11");
    apbWrite(32'h08, 32'h3F);
    waitCyc(70);
    apbRead(32'h04, 0, "R11");
    apbWrite(32'h0C, 32'hF);
    // R11 receive disabled ignores frames
    apbWrite(32'h08, 32'h3D);
    sendSer(8'h77);
    waitCyc(8);
    apbRead(32'h04, 0, "R11");
    // R11 interrupt enables cleared
    apbWrite(32'h08, 32'h03);
    apbWrite(32'h0C, 32'hF);
    apbWrite(32'h00, 32'h12);
    waitCyc(60);
    sendSer(8'h34);
    waitCyc(8);
    apbRead(32'h0C, 0, "R11");
    apbRead(32'h00, 32'h34, "R11");
    waitCyc(5);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule